// File: doc/BRIEF.md
# Pseudo-Random Logic Self-Test Engine

This block wraps a combinational logic block under test and exercises it without any stored test vectors. An external start request launches a run: a 16-bit linear feedback shift register drives a new pseudo-random stimulus word onto the block under test on every system-clock cycle, and the response word that comes back on the same cycle is folded into a 16-bit multiple-input signature register. Both run on the system clock, so patterns are applied at full speed.

The number of patterns is taken from a count input when the run is accepted. When that many patterns have been applied, the busy flag falls and a one-cycle done pulse marks the end. The final signature is then held on its output so that an outside tester can compare it, and the engine also compares it with an expected-signature input and reports the outcome on a pass flag. The generator is reseeded at the start of every run, so the same count and the same logic always give the same signature.

Top module: `lbist_engine`

## Requirements
- R1: After reset, busy, done and pass are 0, the signature is 0 and the stimulus output holds the seed 16'hACE1.
- R2: A run is accepted only when start is 1 while busy is 0; in the cycle after acceptance (for a nonzero count) busy is 1 and the stimulus output equals the seed 16'hACE1.
- R3: The stimulus advances once per busy cycle by a right-shifting Galois step: next = state >> 1, XORed with 16'hB400 when bit 0 of state was 1 (polynomial x^16+x^14+x^13+x^11+1); it never becomes zero.
- R4: For a pattern count N, busy stays 1 for exactly N cycles and done is 1 for exactly one cycle, the first cycle after busy falls; with N = 0 busy never rises and done pulses in the cycle after acceptance.
- R5: The signature is cleared on acceptance, and on each busy cycle becomes (its Galois step, same polynomial) XOR the response input sampled in that cycle.
- R6: Once done has pulsed, the signature stays unchanged until the next accepted start.
- R7: Pass is 1 only from the done cycle onward, while the held signature equals the expected-signature input (the value one clock earlier); it is 0 while busy and before any run has completed.
- R8: A start request while busy has no effect on the run length, stimulus sequence or signature.
- R9: The pattern count is captured at acceptance; changes to it during a run have no effect.
- R10: Every run begins from the seed and a cleared signature, so repeating a run with the same count gives the same signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Run request |
| pat_cnt_i | input | 16 | Number of patterns to apply, captured at acceptance |
| exp_sig_i | input | 16 | Expected signature for the internal compare |
| rsp_i | input | 16 | Response word from the logic under test |
| stim_o | output | 16 | Stimulus word to the logic under test |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| sig_o | output | 16 | Compacted signature |
| pass_o | output | 1 | Held signature matches the expected value |

## Verification
The bench models the logic under test as a mixing function of the stimulus word and computes the expected pattern sequence and signature itself. Runs with counts 0 and 1 separate the empty-run and single-pattern edge of the counter from an off-by-one in the length, while random counts up to a few hundred show that the generator and compactor stay in step over long sequences. A run repeated with the same count tells reseeding apart from a generator that carries on from its last state, and start and count changes injected mid-run distinguish a captured count and a locked-out start from ones that leak into the run. Matching and mismatching expected values, including one changed after done, show that pass follows the held signature and nothing else.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  localparam int unsigned SIG_W_DEF = 16;
  localparam logic [15:0] POLY_DEF  = 16'hB400;
  localparam logic [15:0] SEED_DEF  = 16'hACE1;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/lbist_lfsr.sv
module lbist_lfsr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] POLY = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_step;

  always_comb begin
    st_step = {1'b0, st_q[W-1:1]};
    if (st_q[0]) st_step = st_step ^ POLY;
  end

  always_ff @(posedge clk) begin
    if (rst || load_i) st_q <= SEED;
    else if (adv_i)    st_q <= st_step;
  end

  assign state_o = st_q;

  // R3: a maximal-length generator never reaches the all-zero lockup state
  always @(posedge clk)
    if (!rst) a_r3_lfsr_nonzero: assert (st_q != '0);

  // R3: the state only moves when advanced or reloaded
  a_r3_lfsr_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !load_i) |=> $stable(st_q));
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] POLY = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] rsp_i,
  output logic [W-1:0] sig_o,
  output logic [W-1:0] sig_nxt_o
);
  logic [W-1:0] sig_q;
  logic [W-1:0] sig_step;

  always_comb begin
    sig_step = {1'b0, sig_q[W-1:1]};
    if (sig_q[0]) sig_step = sig_step ^ POLY;
    sig_step = sig_step ^ rsp_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) sig_q <= '0;
    else if (en_i)    sig_q <= sig_step;
  end

  assign sig_o     = sig_q;
  assign sig_nxt_o = en_i ? sig_step : sig_q;

  // R5: a clear always leaves a zero signature
  a_r5_misr_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (sig_q == '0));
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] pat_cnt_i,
  output logic             load_o,
  output logic             run_o,
  output logic             fin_o,
  output logic             done_o,
  output logic             held_o
);
  run_state_e       st_q;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] idx_q;
  logic             done_q;
  logic             held_q;
  logic             zero_req;

  assign load_o   = start_i && (st_q == ST_IDLE);
  assign run_o    = (st_q == ST_RUN);
  assign fin_o    = run_o && (idx_q == n_q - CNT_W'(1));
  assign zero_req = (pat_cnt_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      n_q    <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        n_q    <= pat_cnt_i;
        idx_q  <= '0;
        held_q <= zero_req;
        done_q <= zero_req;
        st_q   <= zero_req ? ST_IDLE : ST_RUN;
      end else if (run_o) begin
        idx_q <= idx_q + CNT_W'(1);
        if (fin_o) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
          held_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign held_o = held_q;

  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R8: a run continues until its final pattern, whatever start does
  a_r8_run_holds: assert property (@(posedge clk) disable iff (rst)
    (run_o && !fin_o) |=> run_o);

  // R4: the final pattern is followed by idle and a done pulse
  a_r4_fin_done: assert property (@(posedge clk) disable iff (rst)
    fin_o |=> (done_q && !run_o));

  // R9: the captured count does not move during a run
  a_r9_count_held: assert property (@(posedge clk) disable iff (rst)
    (run_o && !fin_o) |=> $stable(n_q));
endmodule

// File: rtl/lbist_engine.sv
module lbist_engine
  import lbist_pkg::*;
#(
  parameter int unsigned   SIG_W = 16,
  parameter int unsigned   CNT_W = 16,
  parameter logic [SIG_W-1:0] POLY = 16'hB400,
  parameter logic [SIG_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] pat_cnt_i,
  input  logic [SIG_W-1:0] exp_sig_i,
  input  logic [SIG_W-1:0] rsp_i,
  output logic [SIG_W-1:0] stim_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [SIG_W-1:0] sig_o,
  output logic             pass_o
);
  logic             load;
  logic             run;
  logic             fin;
  logic             held;
  logic [SIG_W-1:0] sig_nxt;
  logic             pass_q;

  lbist_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .pat_cnt_i(pat_cnt_i),
    .load_o   (load),
    .run_o    (run),
    .fin_o    (fin),
    .done_o   (done_o),
    .held_o   (held)
  );

  lbist_lfsr #(.W(SIG_W), .POLY(POLY), .SEED(SEED)) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .adv_i  (run),
    .state_o(stim_o)
  );

  lbist_misr #(.W(SIG_W), .POLY(POLY)) u_misr (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (load),
    .en_i     (run),
    .rsp_i    (rsp_i),
    .sig_o    (sig_o),
    .sig_nxt_o(sig_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)       pass_q <= 1'b0;
    else if (load) pass_q <= (pat_cnt_i == '0) && (exp_sig_i == '0);
    else if (fin)  pass_q <= (sig_nxt == exp_sig_i);
    else if (held) pass_q <= (sig_o == exp_sig_i);
    else           pass_q <= 1'b0;
  end

  assign busy_o = run;
  assign pass_o = pass_q;

  // R7: no pass indication while a run is in progress
  a_r7_no_pass_busy: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !pass_o);

  // R6: the held signature only changes on an accepted start
  a_r6_sig_hold: assert property (@(posedge clk) disable iff (rst)
    (held && !load) |=> $stable(sig_o));

  // R2: a start that arrives during a run does not restart the generator
  a_r2_no_reload_busy: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !fin) |=> busy_o);
endmodule

// File: tb/tb_lbist_engine.sv
module tb_lbist_engine;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam logic [15:0] POLY = 16'hB400;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [15:0] pat_cnt_i;
  logic [15:0] exp_sig_i;
  logic [15:0] rsp_i;
  logic [15:0] stim_o;
  logic        busy_o;
  logic        done_o;
  logic [15:0] sig_o;
  logic        pass_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lbist_engine dut (
    .clk(clk), .rst(rst), .start_i(start_i), .pat_cnt_i(pat_cnt_i),
    .exp_sig_i(exp_sig_i), .rsp_i(rsp_i), .stim_o(stim_o), .busy_o(busy_o),
    .done_o(done_o), .sig_o(sig_o), .pass_o(pass_o)
  );

  function automatic logic [15:0] gstep(input logic [15:0] s);
    return s[0] ? ({1'b0, s[15:1]} ^ POLY) : {1'b0, s[15:1]};
  endfunction

  function automatic logic [15:0] cut(input logic [15:0] x);
    return {x[7:0] ^ x[15:8], x[15:8] + x[7:0]} ^ {x[3:0], x[15:4]};
  endfunction

  assign rsp_i = cut(stim_o);

  function automatic logic [15:0] model_sig(input int n);
    logic [15:0] s = '0;
    logic [15:0] p = SEED;
    for (int k = 0; k < n; k++) begin
      s = gstep(s) ^ cut(p);
      p = gstep(p);
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // poke: 1 = start pulse mid-run (R8), 2 = count change mid-run (R9)
  task automatic do_run(input int n, input bit good_exp, input int poke,
                        output logic [15:0] got);
    logic [15:0] want = model_sig(n);
    logic [15:0] p = SEED;
    int cyc = 0;
    @(negedge clk);
    start_i = 1'b1; pat_cnt_i = 16'(n);
    exp_sig_i = good_exp ? want : ~want;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == (n != 0), "R2 busy after start", busy_o, n != 0);
    if (n != 0) chk(stim_o == SEED, "R2 seed stimulus", stim_o, SEED);
    chk(sig_o == 16'h0 || n == 0, "R5 cleared signature", sig_o, 0);
    while (busy_o && cyc < 70000) begin
      if (stim_o != p) chk(1'b0, "R3 stimulus sequence", stim_o, p);
      chk(!pass_o, "R7 pass low while busy", pass_o, 0);
      p = gstep(p);
      cyc++;
      if (cyc == 2 && poke == 1) begin start_i = 1'b1; pat_cnt_i = 16'd3; end
      else if (cyc == 2 && poke == 2) pat_cnt_i = 16'(n + 50);
      else if (cyc == 3) start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(cyc == n, poke == 1 ? "R8 run length with start while busy" :
                  poke == 2 ? "R9 run length with count change" : "R4 busy length",
        cyc, n);
    chk(done_o == 1'b1, "R4 done pulse", done_o, 1);
    chk(sig_o == want, "R5 signature", sig_o, want);
    chk(pass_o == good_exp, "R7 pass at done", pass_o, good_exp);
    got = sig_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R4 done one cycle", done_o, 0);
    chk(sig_o == want, "R6 signature held", sig_o, want);
    chk(pass_o == good_exp, "R7 pass held", pass_o, good_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] s1, s2;
    void'($urandom(1234));
    rst = 1'b1; start_i = 1'b0; pat_cnt_i = '0; exp_sig_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !pass_o, "R1 reset flags", {busy_o, done_o, pass_o}, 0);
    chk(sig_o == 16'h0, "R1 reset signature", sig_o, 0);
    chk(stim_o == SEED, "R1 reset stimulus", stim_o, SEED);

    do_run(1, 1'b1, 0, s1);
    do_run(0, 1'b1, 0, s1);
    do_run(0, 1'b0, 0, s1);
    do_run(5, 1'b1, 0, s1);
    do_run(20, 1'b1, 1, s1);
    do_run(20, 1'b1, 2, s2);
    chk(s1 == s2, "R10 repeat gives same signature", s2, s1);
    do_run(37, 1'b0, 0, s1);

    // R7: pass follows the expected input after done
    do_run(12, 1'b1, 0, s1);
    exp_sig_i = ~s1;
    @(negedge clk);
    chk(pass_o == 1'b0, "R7 pass drops on new expected", pass_o, 0);
    exp_sig_i = s1;
    @(negedge clk);
    chk(pass_o == 1'b1, "R7 pass returns", pass_o, 1);
    repeat (5) @(negedge clk);
    chk(sig_o == s1, "R6 signature idle hold", sig_o, s1);

    for (int i = 0; i < 12; i++) begin
      int n = int'($urandom % 300) + 1;
      do_run(n, ($urandom % 2) == 0, 0, s1);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule